// File: doc/BRIEF.md
# DMA Channel Mask and Status Control

This block holds the programming and supervision state for a multi-channel DMA controller (four channels by default). Software reaches it through a small address/data register port. It can store a per-channel operating mode, raise or drop a software request for a channel, and enable or disable channels one at a time or all at once. It can also read a status byte that shows which channels have finished their transfer count and which hardware request lines are active.

Hardware service requests arrive on one line per channel and pass through an optional synchronizer. Each line is then OR-ed with the software request for that channel. The result is gated by that channel's mask and drives an effective request vector, which the priority arbiter uses. The channel engines pulse one terminal-count line per channel when a transfer completes. That pulse sets a sticky status flag and drops any software request on the channel. It also disables the channel, unless the channel's mode selects auto-initialization.

Arbitration between channels and the data movement itself are handled elsewhere.

Top module: `dmac_ctl`

## Requirements
- R1: While reset is asserted, every channel mask is set. Software requests, terminal-count flags and stored modes are all zero, and no effective request is driven.
- R2: A write to address 0 selects the channel given by data bits 1:0. It stores data bits 7:2 as that channel's 6-bit mode on `mode_o[6c+5:6c]`, and the modes of all other channels stay unchanged. Within the stored mode, bits 1:0 are the operation, bit 2 is auto-initialization, bit 3 selects a decrementing address and bits 5:4 are the transfer mode.
- R3: A write to address 1 changes one channel's mask. Data bits 1:0 select the channel, bit 2 = 1 sets the mask and bit 2 = 0 clears it. No other mask changes.
- R4: A write to address 2 loads all masks at once from data bits N_CH-1:0, where bit c is channel c.
- R5: A write to address 3 changes one channel's software request. Data bits 1:0 select the channel, bit 2 = 1 raises the request and bit 2 = 0 drops it. A read of address 2 returns the software request vector in its low bits.
- R6: `eff_req_o[c]` is the synchronized hardware request OR the software request of channel c, forced low while mask c is set. A read of address 1 returns the mask vector in its low bits and has no side effect.
- R7: A read of address 0 returns the terminal-count flags in bits 3:0 and the synchronized hardware request levels in bits 7:4, with bit c or 4+c belonging to channel c. The read then clears all terminal-count flags at the closing clock edge.
- R8: A terminal-count pulse on `tc_i[c]` sets flag c in the status byte and clears software request c.
- R9: At a terminal-count pulse, channel c's mask is set if its stored mode bit 2 (auto-initialization) is 0, and left unchanged if that bit is 1.
- R10: If a terminal-count pulse and a status read fall in the same cycle, the read returns the old flags and the new flag remains set afterwards.
- R11: A change on `dreq_i` reaches `eff_req_o` and the status request bits after exactly SYNC_STAGES rising clock edges.
- R12: A terminal-count pulse takes precedence over a software write in the same cycle. A mask clear cannot keep a non-auto-initializing channel enabled, and a software request raised in that cycle ends cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (status read has a clear side effect) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from address |
| dreq_i | input | N_CH | Hardware service request per channel |
| tc_i | input | N_CH | Terminal-count pulse per channel from the channel engines |
| eff_req_o | output | N_CH | Unmasked hardware-or-software request per channel |
| mode_o | output | 6*N_CH | Stored mode of each channel, channel c in bits 6c+5:6c |

## Verification
A bad mask bit appears at once as a missing or extra bit on `eff_req_o`, and on the very next mask readback. A wrong terminal-count flag is caught on the next status read. A missing clear appears as the same flag on a second read one transaction later. A software request that a terminal count failed to clear still drives `eff_req_o` in the cycle after the pulse. The collision cases need the pulse to land on the exact edge of a register access, so the bench drives both in one cycle.

// File: rtl/dmac_ctl_pkg.sv
package dmac_ctl_pkg;
   localparam int DATA_W   = 8;
   localparam int SEL_W    = 2;
   localparam int MODE_W   = 6;
   localparam int ADDR_W   = 2;
   localparam int MAX_CH   = 4;
   localparam int AUTO_BIT = 2;   // auto-initialization bit inside stored mode
   localparam int ONOFF_BIT = 2;  // set/clear bit in single-channel commands

   typedef enum logic [ADDR_W-1:0] {
      REG_MODE_STAT = 2'd0,
      REG_SMASK     = 2'd1,
      REG_AMASK     = 2'd2,
      REG_SWREQ     = 2'd3
   } reg_addr_e;
endpackage

// File: rtl/dmac_dreq_sync.sv
module dmac_dreq_sync #(
   parameter int N_CH   = 4,
   parameter int STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CH-1:0] req_in,
   output logic [N_CH-1:0] req_out
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign req_out = req_in;
      end else begin : g_chain
         logic [STAGES-1:0][N_CH-1:0] stg_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg_q <= '0;
            end else begin
               stg_q[0] <= req_in;
               for (int s = 1; s < STAGES; s++) begin
                  stg_q[s] <= stg_q[s-1];
               end
            end
         end
         assign req_out = stg_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/dmac_regif.sv
module dmac_regif
   import dmac_ctl_pkg::*;
#(
   parameter int N_CH = 4
) (
   input  logic                     wr_en,
   input  logic                     rd_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        wdata,
   input  logic [N_CH-1:0]          tc_vec,
   input  logic [N_CH-1:0]          req_vec,
   input  logic [N_CH-1:0]          mask_vec,
   input  logic [N_CH-1:0]          sw_vec,
   output logic [N_CH-1:0]          mode_we,
   output logic [MODE_W-1:0]        mode_d,
   output logic [N_CH-1:0]          smask_set,
   output logic [N_CH-1:0]          smask_clr,
   output logic                     amask_ld,
   output logic [N_CH-1:0]          amask_d,
   output logic [N_CH-1:0]          sw_set,
   output logic [N_CH-1:0]          sw_clr,
   output logic                     stat_rd,
   output logic [DATA_W-1:0]        rdata
);
   localparam int PAD = MAX_CH - N_CH;

   logic wr_mode, wr_smask, wr_amask, wr_sw;
   logic [SEL_W-1:0] sel;
   logic             onoff;

   assign sel      = wdata[SEL_W-1:0];
   assign onoff    = wdata[ONOFF_BIT];
   assign wr_mode  = wr_en && (addr == REG_MODE_STAT);
   assign wr_smask = wr_en && (addr == REG_SMASK);
   assign wr_amask = wr_en && (addr == REG_AMASK);
   assign wr_sw    = wr_en && (addr == REG_SWREQ);
   assign stat_rd  = rd_en && (addr == REG_MODE_STAT);
   assign mode_d   = wdata[DATA_W-1:SEL_W];
   assign amask_ld = wr_amask;
   assign amask_d  = wdata[N_CH-1:0];

   genvar c;
   generate
      for (c = 0; c < N_CH; c++) begin : g_dec
         logic hit;
         assign hit          = (sel == SEL_W'(c));
         assign mode_we[c]   = wr_mode  && hit;
         assign smask_set[c] = wr_smask && hit && onoff;
         assign smask_clr[c] = wr_smask && hit && !onoff;
         assign sw_set[c]    = wr_sw    && hit && onoff;
         assign sw_clr[c]    = wr_sw    && hit && !onoff;
      end
   endgenerate

   logic [MAX_CH-1:0] tc4, req4, mask4, sw4;
   generate
      if (PAD == 0) begin : g_full
         assign tc4   = tc_vec;
         assign req4  = req_vec;
         assign mask4 = mask_vec;
         assign sw4   = sw_vec;
      end else begin : g_pad
         assign tc4   = {{PAD{1'b0}}, tc_vec};
         assign req4  = {{PAD{1'b0}}, req_vec};
         assign mask4 = {{PAD{1'b0}}, mask_vec};
         assign sw4   = {{PAD{1'b0}}, sw_vec};
      end
   endgenerate

   always_comb begin
      unique case (addr)
         REG_MODE_STAT: rdata = {req4, tc4};
         REG_SMASK:     rdata = {4'b0000, mask4};
         REG_AMASK:     rdata = {4'b0000, sw4};
         default:       rdata = '0;
      endcase
   end
endmodule

// File: rtl/dmac_chan_slice.sv
module dmac_chan_slice
   import dmac_ctl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_we,
   input  logic [MODE_W-1:0] mode_d,
   input  logic              smask_set,
   input  logic              smask_clr,
   input  logic              amask_ld,
   input  logic              amask_bit,
   input  logic              sw_set,
   input  logic              sw_clr,
   input  logic              tc_pulse,
   input  logic              tc_clr,
   output logic [MODE_W-1:0] mode_q,
   output logic              mask_q,
   output logic              sw_q,
   output logic              tc_q
);
   logic auto_init;
   assign auto_init = mode_q[AUTO_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
      end else if (mode_we) begin
         mode_q <= mode_d;
      end
   end

   // terminal count wins over any software update in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= 1'b1;
      end else if (tc_pulse && !auto_init) begin
         mask_q <= 1'b1;
      end else if (amask_ld) begin
         mask_q <= amask_bit;
      end else if (smask_set) begin
         mask_q <= 1'b1;
      end else if (smask_clr) begin
         mask_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_q <= 1'b0;
      end else if (tc_pulse) begin
         sw_q <= 1'b0;
      end else if (sw_set) begin
         sw_q <= 1'b1;
      end else if (sw_clr) begin
         sw_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tc_q <= 1'b0;
      end else if (tc_pulse) begin
         tc_q <= 1'b1;
      end else if (tc_clr) begin
         tc_q <= 1'b0;
      end
   end
endmodule

// File: rtl/dmac_ctl.sv
module dmac_ctl
   import dmac_ctl_pkg::*;
#(
   parameter int N_CH        = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic                     rd_en,
   input  logic [1:0]               addr,
   input  logic [7:0]               wdata,
   output logic [7:0]               rdata,
   input  logic [N_CH-1:0]          dreq_i,
   input  logic [N_CH-1:0]          tc_i,
   output logic [N_CH-1:0]          eff_req_o,
   output logic [6*N_CH-1:0]        mode_o
);
   localparam int MODE_BITS = MODE_W * N_CH;

   generate
      if (N_CH < 1 || N_CH > MAX_CH) begin : g_bad_nch
         $error("dmac_ctl: N_CH must lie in 1..4");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("dmac_ctl: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic [N_CH-1:0]        req_s;
   logic [N_CH-1:0]        mask_q, swreq_q, tc_q;
   logic [N_CH-1:0]        mode_we, smask_set, smask_clr, sw_set, sw_clr;
   logic [N_CH-1:0]        amask_d;
   logic [MODE_W-1:0]      mode_d;
   logic                   amask_ld, stat_rd;
   logic [MODE_BITS-1:0]   mode_flat;

   dmac_dreq_sync #(.N_CH(N_CH), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_in  (dreq_i),
      .req_out (req_s)
   );

   dmac_regif #(.N_CH(N_CH)) u_regif (
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .addr      (addr),
      .wdata     (wdata),
      .tc_vec    (tc_q),
      .req_vec   (req_s),
      .mask_vec  (mask_q),
      .sw_vec    (swreq_q),
      .mode_we   (mode_we),
      .mode_d    (mode_d),
      .smask_set (smask_set),
      .smask_clr (smask_clr),
      .amask_ld  (amask_ld),
      .amask_d   (amask_d),
      .sw_set    (sw_set),
      .sw_clr    (sw_clr),
      .stat_rd   (stat_rd),
      .rdata     (rdata)
   );

   genvar c;
   generate
      for (c = 0; c < N_CH; c++) begin : g_ch
         dmac_chan_slice u_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode_we   (mode_we[c]),
            .mode_d    (mode_d),
            .smask_set (smask_set[c]),
            .smask_clr (smask_clr[c]),
            .amask_ld  (amask_ld),
            .amask_bit (amask_d[c]),
            .sw_set    (sw_set[c]),
            .sw_clr    (sw_clr[c]),
            .tc_pulse  (tc_i[c]),
            .tc_clr    (stat_rd),
            .mode_q    (mode_flat[c*MODE_W +: MODE_W]),
            .mask_q    (mask_q[c]),
            .sw_q      (swreq_q[c]),
            .tc_q      (tc_q[c])
         );
         assign eff_req_o[c] = (req_s[c] | swreq_q[c]) & ~mask_q[c];
      end
   endgenerate

   assign mode_o = mode_flat;
endmodule

// File: rtl/dmac_ctl_chk.sv
module dmac_ctl_chk #(
   parameter int N_CH = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        addr,
   input logic [7:0]        wdata,
   input logic [N_CH-1:0]   tc_i,
   input logic [N_CH-1:0]   mask_q,
   input logic [N_CH-1:0]   swreq_q,
   input logic [N_CH-1:0]   tc_q,
   input logic [N_CH-1:0]   eff_req_o,
   input logic [6*N_CH-1:0] mode_o
);
   AST_RESET_MASKED: assert property (@(posedge clk) !rst_n |=> (&mask_q && eff_req_o == '0)); // R1

   AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && addr == 2'd0) |=> $stable(mode_o)); // R2

   genvar c;
   generate
      for (c = 0; c < N_CH; c++) begin : g_chk
         AST_SMASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == 2'd1 && wdata[1:0] == 2'(c) && wdata[2]) |=> mask_q[c]); // R3

         AST_SMASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == 2'd1 && wdata[1:0] == 2'(c) && !wdata[2] && !tc_i[c]) |=> !mask_q[c]); // R3

         AST_TC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            tc_i[c] |=> tc_q[c]); // R8

         AST_TC_DROP_SW: assert property (@(posedge clk) disable iff (!rst_n)
            tc_i[c] |=> !swreq_q[c]); // R8

         AST_TC_AUTOMASK: assert property (@(posedge clk) disable iff (!rst_n)
            (tc_i[c] && !mode_o[6*c+2]) |=> mask_q[c]); // R9

         AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            mask_q[c] |-> !eff_req_o[c]); // R6
      end
   endgenerate
endmodule

bind dmac_ctl dmac_ctl_chk #(.N_CH(N_CH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .addr      (addr),
   .wdata     (wdata),
   .tc_i      (tc_i),
   .mask_q    (mask_q),
   .swreq_q   (swreq_q),
   .tc_q      (tc_q),
   .eff_req_o (eff_req_o),
   .mode_o    (mode_o)
);

// File: tb/tb_dmac_ctl.sv
`timescale 1ns/1ps
module tb_dmac_ctl;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         wr_en, rd_en;
   logic [1:0]   addr;
   logic [7:0]   wdata;
   logic [7:0]   rdata;
   logic [N-1:0] dreq_i, tc_i, eff_req_o;
   logic [6*N-1:0] mode_o;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;   // 250 MHz

   dmac_ctl #(.N_CH(N), .SYNC_STAGES(2)) dut (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .rd_en (rd_en),
      .addr (addr), .wdata (wdata), .rdata (rdata),
      .dreq_i (dreq_i), .tc_i (tc_i), .eff_req_o (eff_req_o), .mode_o (mode_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic pulse_tc(input logic [N-1:0] v);
      @(negedge clk);
      tc_i = v;
      @(negedge clk);
      tc_i = '0;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk("R1 eff", eff_req_o, 0);
      chk("R1 mode", mode_o, 0);
      rd(2'd1, d); chk("R1 mask", d, 8'h0F);
      rd(2'd0, d); chk("R1 status", d, 8'h00);
      rd(2'd2, d); chk("R1 swreq", d, 8'h00);
   endtask

   task automatic t_mode();
      wr(2'd0, 8'hB6);                 // ch2 gets 6'b101101
      chk("R2 ch2", mode_o, 24'h2D000);
      wr(2'd0, 8'h4D);                 // ch1 gets 6'b010011
      chk("R2 ch1", mode_o, 24'h2D4C0);
   endtask

   task automatic t_masks();
      logic [7:0] d;
      wr(2'd2, 8'h00); rd(2'd1, d); chk("R4 clear all", d, 8'h00);
      wr(2'd1, 8'h05); rd(2'd1, d); chk("R3 set ch1", d, 8'h02);
      wr(2'd1, 8'h07); rd(2'd1, d); chk("R3 set ch3", d, 8'h0A);
      wr(2'd1, 8'h01); rd(2'd1, d); chk("R3 clr ch1", d, 8'h08);
      wr(2'd2, 8'h05); rd(2'd1, d); chk("R4 load 0101", d, 8'h05);
      wr(2'd2, 8'h00);
   endtask

   task automatic t_dreq();
      logic [7:0] d;
      @(negedge clk); dreq_i = 4'b0101;
      @(negedge clk); chk("R11 one edge", eff_req_o, 4'b0000);
      @(negedge clk); chk("R11 two edges", eff_req_o, 4'b0101);
      wr(2'd1, 8'h04);                 // mask ch0
      chk("R6 masked ch0", eff_req_o, 4'b0100);
      rd(2'd0, d); chk("R7 req bits", d, 8'h50);
      @(negedge clk); dreq_i = '0;
      repeat (3) @(negedge clk);
      chk("R11 drop", eff_req_o, 4'b0000);
      wr(2'd2, 8'h00);
   endtask

   task automatic t_swreq();
      logic [7:0] d;
      wr(2'd3, 8'h07);
      rd(2'd2, d); chk("R5 set ch3", d, 8'h08);
      chk("R6 sw drives eff", eff_req_o, 4'b1000);
      wr(2'd1, 8'h07);
      chk("R6 sw masked", eff_req_o, 4'b0000);
      wr(2'd1, 8'h03);
      wr(2'd3, 8'h03);
      rd(2'd2, d); chk("R5 clr ch3", d, 8'h00);
      chk("R6 idle", eff_req_o, 4'b0000);
   endtask

   task automatic t_tc();
      logic [7:0] d;
      wr(2'd3, 8'h05);                 // swreq ch1 (ch1 mode has auto bit 0)
      chk("R6 ch1 sw", eff_req_o, 4'b0010);
      pulse_tc(4'b0010);
      chk("R8 sw dropped", eff_req_o, 4'b0000);
      rd(2'd2, d); chk("R8 sw vec", d, 8'h00);
      rd(2'd1, d); chk("R9 ch1 masked", d, 8'h02);
      pulse_tc(4'b0100);               // ch2 auto-init set
      rd(2'd1, d); chk("R9 ch2 stays open", d, 8'h02);
      rd(2'd0, d); chk("R7 tc flags", d, 8'h06);
      rd(2'd0, d); chk("R7 cleared", d, 8'h00);
      wr(2'd2, 8'h00);
   endtask

   task automatic t_collide();
      logic [7:0] d;
      @(negedge clk);
      rd_en = 1'b1; addr = 2'd0; tc_i = 4'b0001;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0; tc_i = '0;
      chk("R10 old flags", d, 8'h00);
      rd(2'd0, d); chk("R10 flag kept", d, 8'h01);
      wr(2'd2, 8'h00);
      @(negedge clk);
      wr_en = 1'b1; addr = 2'd1; wdata = 8'h03; tc_i = 4'b1000;
      @(negedge clk);
      wr_en = 1'b0; tc_i = '0;
      rd(2'd1, d); chk("R12 tc beats clear", d, 8'h08);
      @(negedge clk);
      wr_en = 1'b1; addr = 2'd3; wdata = 8'h04; tc_i = 4'b0001;
      @(negedge clk);
      wr_en = 1'b0; tc_i = '0;
      rd(2'd2, d); chk("R12 tc beats sw set", d, 8'h00);
   endtask

   task automatic finish_sim();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
      dreq_i = '0; tc_i = '0;
      repeat (3) @(negedge clk);
      chk("R1 in reset", eff_req_o, 0);
      rst_n = 1'b1;
      t_reset();
      t_mode();
      t_masks();
      t_dreq();
      t_swreq();
      t_tc();
      t_collide();
      finish_sim();
   end

   initial begin
      #100000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
   end
endmodule